// File: doc/BRIEF.md
# Multi-Lane Pipelined AES-128 Block Encryptor

This block encrypts 128-bit data blocks with AES-128 in electronic codebook mode. It has a configurable number of independent encryption lanes. Each lane is fully unrolled, so every round is its own piece of hardware, and each lane accepts one new block on every clock. Registers sit only between whole rounds. The lanes hold no key logic of their own: one key-expansion unit builds the eleven round keys once, stores them, and drives the same round keys into every lane.

Software loads a key by pulsing a strobe with the key on a dedicated port. The key-expansion unit waits until no block is left in any lane pipeline. It then expands the key, one round key per clock, and raises a ready flag. The lanes take data only while that flag is high. A valid bit travels with each block, so the output side of each lane carries its own valid flag after a fixed latency.

Top module: `aes_multi_lane`

## Requirements
- R1: While reset is held and in the first cycle after it, key_ready is 0 and out_valid is all zeros.
- R2: When key_load is sampled high and no block is in flight, key_ready reads 0 from the next cycle and reads 1 again 12 cycles after the cycle in which key_load was driven.
- R3: Once high, key_ready stays high until the next key_load.
- R4: A lane accepts a block only in a cycle where both its in_valid bit and key_ready are high. A block offered while key_ready is low produces no output.
- R5: A block accepted in cycle c appears on its lane with out_valid set in cycle c+11, for exactly one cycle per block. Blocks offered back to back come out back to back.
- R6: Blocks and keys are big-endian: bits [127:120] hold the first byte. Key 000102030405060708090A0B0C0D0E0F with plaintext 00112233445566778899AABBCCDDEEFF gives 69C4E0D86A7B0430D8CDB78070B4C55A on every lane. Key 2B7E151628AED2A6ABF7158809CF4F3C with plaintext 3243F6A8885A308D313198A2E0370734 gives 3925841D02DC09FBDC118597196A0B32.
- R7: Lanes are independent. Lane i uses bits [128*i+127:128*i] of in_data and out_data, and a lane's result does not depend on the activity or data of the other lanes. All lanes use the one loaded key.
- R8: Each block is encrypted on its own (ECB). Equal plaintexts under the same key give equal ciphertexts, whatever lane and cycle they use.
- R9: A key_load issued while blocks are in flight lets those blocks finish under the old key. key_ready rises 11 cycles after the pipelines have drained. For a block accepted in the same cycle as key_load, key_ready reads 1 again 23 cycles after that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| key_load | input | 1 | Strobe: take key_in as the new cipher key |
| key_in | input | 128 | Cipher key, first byte in bits [127:120] |
| key_ready | output | 1 | Round keys are valid; lanes accept data |
| in_valid | input | LANES | Per-lane input block valid |
| in_data | input | 128*LANES | Per-lane plaintext blocks, lane 0 in the low bits |
| out_valid | output | LANES | Per-lane ciphertext valid |
| out_data | output | 128*LANES | Per-lane ciphertext blocks, lane 0 in the low bits |

## Verification
Assertions check on every cycle that each lane's output valid equals its accepted-input flag from 11 cycles earlier, which also shows that offers made while not ready vanish. They also check that key_ready drops right after a load and otherwise holds, and that it never rises while any lane still shows output. Only the bench's scenarios can show that the ciphertext values are correct. It compares them against a behavioural reference and two known-answer vectors, checks that equal plaintexts in different lanes and cycles match, and checks that blocks in flight during a key change finish under the old key and that the ready-return delay matches the drain time.

// File: rtl/aes_pkg.sv
// Package aes_pkg
// Shared types and pure functions for the AES-128 encryptor: field
// arithmetic in GF(2^8), the byte substitution (computed, not tabulated),
// one key-schedule step and one encryption round.
// Assumes big-endian byte order: byte 0 of a block sits in bits [127:120].
package aes_pkg;

    localparam int BLK_W         = 128;
    localparam int AES128_ROUNDS = 10;

    typedef logic [BLK_W-1:0] blk_t;

    // Multiply by x modulo the AES field polynomial.
    function automatic logic [7:0] gf_dbl(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    // General field multiply, shift-and-add.
    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] x;
        acc = 8'h00;
        x   = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ x;
            x = gf_dbl(x);
        end
        return acc;
    endfunction

    function automatic logic [7:0] rotl8(input logic [7:0] b, input int n);
        return (b << n) | (b >> (8 - n));
    endfunction

    // Byte substitution: multiplicative inverse (a^254) then affine map.
    function automatic logic [7:0] sub_byte(input logic [7:0] a);
        logic [7:0] inv;
        logic [7:0] sq;
        inv = 8'h01;
        sq  = a;
        for (int i = 1; i < 8; i++) begin
            sq  = gf_mul(sq, sq);
            inv = gf_mul(inv, sq);
        end
        return inv ^ rotl8(inv, 1) ^ rotl8(inv, 2) ^ rotl8(inv, 3) ^ rotl8(inv, 4) ^ 8'h63;
    endfunction

    // Round constant for key-schedule step idx (1..10).
    function automatic logic [7:0] round_const(input int idx);
        logic [7:0] r;
        r = 8'h01;
        for (int j = 1; j < AES128_ROUNDS; j++) begin
            if (j < idx) r = gf_dbl(r);
        end
        return r;
    endfunction

    // One AES-128 key-schedule step: previous round key to the next one.
    function automatic blk_t next_round_key(input blk_t prev, input logic [7:0] rc);
        logic [31:0] w3;
        logic [31:0] t;
        logic [31:0] n0, n1, n2, n3;
        w3 = prev[31:0];
        t  = {sub_byte(w3[23:16]), sub_byte(w3[15:8]), sub_byte(w3[7:0]), sub_byte(w3[31:24])}
             ^ {rc, 24'h000000};
        n0 = prev[127:96] ^ t;
        n1 = prev[95:64]  ^ n0;
        n2 = prev[63:32]  ^ n1;
        n3 = prev[31:0]   ^ n2;
        return {n0, n1, n2, n3};
    endfunction

    // One full round: substitute, shift rows, mix columns unless last, add key.
    function automatic blk_t enc_round(input blk_t st, input blk_t rk, input logic last);
        logic [7:0] b [16];
        logic [7:0] s [16];
        logic [7:0] a0, a1, a2, a3;
        blk_t       o;
        for (int i = 0; i < 16; i++) b[i] = sub_byte(st[127-8*i -: 8]);
        for (int c = 0; c < 4; c++)
            for (int r = 0; r < 4; r++)
                s[4*c+r] = b[4*((c+r)%4)+r];
        if (!last) begin
            for (int c = 0; c < 4; c++) begin
                a0 = s[4*c];   a1 = s[4*c+1];
                a2 = s[4*c+2]; a3 = s[4*c+3];
                s[4*c]   = gf_dbl(a0) ^ gf_dbl(a1) ^ a1 ^ a2 ^ a3;
                s[4*c+1] = a0 ^ gf_dbl(a1) ^ gf_dbl(a2) ^ a2 ^ a3;
                s[4*c+2] = a0 ^ a1 ^ gf_dbl(a2) ^ gf_dbl(a3) ^ a3;
                s[4*c+3] = gf_dbl(a0) ^ a0 ^ a1 ^ a2 ^ gf_dbl(a3);
            end
        end
        for (int i = 0; i < 16; i++) o[127-8*i -: 8] = s[i];
        return o ^ rk;
    endfunction

endpackage

// File: rtl/aes_key_sched.sv
// Module aes_key_sched
// Shared key-expansion unit. On a load strobe it captures the key and drops
// ready. It waits for the lane pipelines to drain, then computes one round
// key per clock into storage and raises ready after the last one.
// Assumes: drained is high only when no lane holds a valid block. The
// stored round keys stay constant while ready is high.
module aes_key_sched
    import aes_pkg::*;
#(
    parameter int NR = AES128_ROUNDS
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  blk_t key,
    input  logic drained,
    output blk_t rk [NR+1],
    output logic ready
);

    localparam int CW = $clog2(NR + 1);

    logic          pend;
    logic          expand;
    logic [CW-1:0] step;
    blk_t          held;
    blk_t          prev;
    blk_t          step_key;

    assign step_key = next_round_key(prev, round_const(int'(step)));

    // Control sequence: load -> wait for drain -> expand -> ready.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend   <= 1'b0;
            expand <= 1'b0;
            step   <= '0;
            ready  <= 1'b0;
        end else if (load) begin
            pend   <= 1'b1;
            expand <= 1'b0;
            ready  <= 1'b0;
        end else if (pend && drained) begin
            pend   <= 1'b0;
            expand <= 1'b1;
            step   <= CW'(1);
        end else if (expand) begin
            step <= step + CW'(1);
            if (step == CW'(NR)) begin
                expand <= 1'b0;
                ready  <= 1'b1;
            end
        end
    end

    // Key storage: capture the key, then fill round keys in order.
    always_ff @(posedge clk) begin
        if (load) begin
            held <= key;
        end else if (pend && drained) begin
            rk[0] <= held;
            prev  <= held;
        end else if (expand) begin
            rk[step] <= step_key;
            prev     <= step_key;
        end
    end

endmodule

// File: rtl/aes_lane.sv
// Module aes_lane
// One fully unrolled encryption lane: the initial key addition plus NR
// rounds, each followed by a register, giving NR+1 stages. A valid bit runs
// beside the data. Accepts a block every clock.
// Assumes: the round keys are stable while any stage holds a valid block.
module aes_lane
    import aes_pkg::*;
#(
    parameter int NR = AES128_ROUNDS
) (
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  blk_t din,
    input  blk_t rk [NR+1],
    output logic dout_v,
    output blk_t dout,
    output logic busy
);

    blk_t        stg_d [NR+1];
    blk_t        nxt   [NR+1];
    logic [NR:0] stg_v;

    assign nxt[0] = din ^ rk[0];

    for (genvar s = 1; s <= NR; s++) begin : g_round
        assign nxt[s] = enc_round(stg_d[s-1], rk[s], (s == NR));
    end

    // Valid flags shift one stage per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) stg_v <= '0;
        else        stg_v <= {stg_v[NR-1:0], take};
    end

    // Data registers at every round boundary.
    always_ff @(posedge clk) begin
        for (int s = 0; s <= NR; s++) stg_d[s] <= nxt[s];
    end

    assign dout   = stg_d[NR];
    assign dout_v = stg_v[NR];
    assign busy   = |stg_v;

endmodule

// File: rtl/aes_multi_lane.sv
// Module aes_multi_lane
// Top level: LANES parallel encryption lanes fed by one shared key
// schedule. A lane takes a block when its in_valid and key_ready are high.
// A key load waits for all lanes to drain before the round keys change.
// Assumes: lane l uses bits [128*l +: 128] of in_data and out_data.
module aes_multi_lane
    import aes_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   key_load,
    input  logic [BLK_W-1:0]       key_in,
    output logic                   key_ready,
    input  logic [LANES-1:0]       in_valid,
    input  logic [LANES*BLK_W-1:0] in_data,
    output logic [LANES-1:0]       out_valid,
    output logic [LANES*BLK_W-1:0] out_data
);

    localparam int NR = AES128_ROUNDS;

    blk_t             rk [NR+1];
    logic [LANES-1:0] lane_busy;
    logic             all_drained;

    assign all_drained = ~|lane_busy;

    aes_key_sched #(.NR(NR)) u_sched (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (key_load),
        .key     (key_in),
        .drained (all_drained),
        .rk      (rk),
        .ready   (key_ready)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        aes_lane #(.NR(NR)) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .take   (in_valid[l] & key_ready),
            .din    (in_data[l*BLK_W +: BLK_W]),
            .rk     (rk),
            .dout_v (out_valid[l]),
            .dout   (out_data[l*BLK_W +: BLK_W]),
            .busy   (lane_busy[l])
        );
    end

endmodule

// File: rtl/aes_multi_lane_chk.sv
// Module aes_multi_lane_chk
// Protocol checker for aes_multi_lane, bound to every instance of it.
// Assumes the fixed 11-stage lane depth of AES-128.
module aes_multi_lane_chk #(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             key_load,
    input logic             key_ready,
    input logic [LANES-1:0] in_valid,
    input logic [LANES-1:0] out_valid
);

    logic [3:0] age;

    // Cycles since reset, saturating, to gate the latency window.
    always_ff @(posedge clk) begin
        if (!rst_n)              age <= 4'd0;
        else if (age != 4'd15)   age <= age + 4'd1;
    end

    AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n) key_load |=> !key_ready); // R2

    AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (key_ready && !key_load) |=> key_ready); // R3

    AST_READY_ON_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) $rose(key_ready) |-> (out_valid == '0)); // R9

    for (genvar l = 0; l < LANES; l++) begin : g_lat
        AST_LANE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) (age >= 4'd12) |-> (out_valid[l] == $past(in_valid[l] && key_ready, 11))); // R5
    end

endmodule

bind aes_multi_lane aes_multi_lane_chk #(.LANES(LANES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .key_load  (key_load),
    .key_ready (key_ready),
    .in_valid  (in_valid),
    .out_valid (out_valid)
);

// File: tb/tb_aes_multi_lane.sv
// Bench for aes_multi_lane: a behavioural byte-array AES model with
// per-lane queues of expected results, compared on every clock.
module tb_aes_multi_lane;

    localparam int CLK_PERIOD = 10;
    localparam int NL         = 3;
    localparam int BW         = 128;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              key_load = 1'b0;
    logic [BW-1:0]     key_in = '0;
    logic              key_ready;
    logic [NL-1:0]     in_valid = '0;
    logic [NL*BW-1:0]  in_data = '0;
    logic [NL-1:0]     out_valid;
    logic [NL*BW-1:0]  out_data;

    aes_multi_lane #(.LANES(NL)) dut (
        .clk(clk), .rst_n(rst_n), .key_load(key_load), .key_in(key_in),
        .key_ready(key_ready), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    logic [7:0] sb [256];

    initial begin
        logic [7:0] p, q, x;
        p = 8'h01;
        q = 8'h01;
        do begin
            p = p ^ {p[6:0], 1'b0} ^ (p[7] ? 8'h1b : 8'h00);
            q = q ^ {q[6:0], 1'b0};
            q = q ^ {q[5:0], 2'b00};
            q = q ^ {q[3:0], 4'h0};
            if (q[7]) q = q ^ 8'h09;
            x = q ^ {q[6:0], q[7]} ^ {q[5:0], q[7:6]} ^ {q[4:0], q[7:5]} ^ {q[3:0], q[7:4]};
            sb[p] = x ^ 8'h63;
        end while (p != 8'h01);
        sb[0] = 8'h63;
    end

    function automatic logic [7:0] xt(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic logic [127:0] ref_enc(input logic [127:0] k, input logic [127:0] pt);
        logic [7:0]   w [176];
        logic [7:0]   s [16];
        logic [7:0]   t [16];
        logic [7:0]   tmp [4];
        logic [7:0]   rc, x, a0, a1, a2, a3;
        logic [127:0] r;
        rc = 8'h01;
        for (int i = 0; i < 16; i++) w[i] = k[127-8*i -: 8];
        for (int i = 16; i < 176; i += 4) begin
            for (int j = 0; j < 4; j++) tmp[j] = w[i-4+j];
            if (i % 16 == 0) begin
                x = tmp[0];
                tmp[0] = sb[tmp[1]] ^ rc;
                tmp[1] = sb[tmp[2]];
                tmp[2] = sb[tmp[3]];
                tmp[3] = sb[x];
                rc = xt(rc);
            end
            for (int j = 0; j < 4; j++) w[i+j] = w[i-16+j] ^ tmp[j];
        end
        for (int i = 0; i < 16; i++) s[i] = pt[127-8*i -: 8] ^ w[i];
        for (int rnd = 1; rnd <= 10; rnd++) begin
            for (int i = 0; i < 16; i++) t[i] = sb[s[i]];
            for (int c = 0; c < 4; c++)
                for (int rw = 0; rw < 4; rw++)
                    s[4*c+rw] = t[4*((c+rw)%4)+rw];
            if (rnd < 10) begin
                for (int c = 0; c < 4; c++) begin
                    a0 = s[4*c]; a1 = s[4*c+1]; a2 = s[4*c+2]; a3 = s[4*c+3];
                    s[4*c]   = xt(a0 ^ a1) ^ a1 ^ a2 ^ a3;
                    s[4*c+1] = xt(a1 ^ a2) ^ a0 ^ a2 ^ a3;
                    s[4*c+2] = xt(a2 ^ a3) ^ a0 ^ a1 ^ a3;
                    s[4*c+3] = xt(a3 ^ a0) ^ a0 ^ a1 ^ a2;
                end
            end
            for (int i = 0; i < 16; i++) s[i] = s[i] ^ w[16*rnd+i];
        end
        for (int i = 0; i < 16; i++) r[127-8*i -: 8] = s[i];
        return r;
    endfunction

    // ---------------- cycle model ----------------
    int           cyc = 0;
    int           last_due = -100;
    int           rdy_edge = 1 << 30;
    bit           m_ready = 1'b0;
    logic [127:0] m_key = '0;
    int           dueq [NL][$];
    logic [127:0] ctq  [NL][$];

    // Model state update at each edge: accepts, ready return, key loads.
    always @(posedge clk) begin
        if (rst_n) begin
            cyc++;
            for (int l = 0; l < NL; l++) begin
                if (in_valid[l] && m_ready) begin
                    dueq[l].push_back(cyc + 10);
                    ctq[l].push_back(ref_enc(m_key, in_data[l*BW +: BW]));
                    last_due = cyc + 10;
                end
            end
            if (!m_ready && cyc >= rdy_edge) m_ready = 1'b1;
            if (key_load) begin
                m_key    = key_in;
                m_ready  = 1'b0;
                rdy_edge = ((cyc > last_due + 1) ? cyc : last_due + 1) + 11;
            end
        end
    end

    // Every-cycle comparison of the outputs against the model.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(key_ready == m_ready, "R2 R3 R9 key_ready", 128'(key_ready), 128'(m_ready));
            for (int l = 0; l < NL; l++) begin
                bit ev;
                ev = (dueq[l].size() > 0) && (dueq[l][0] == cyc);
                chk(out_valid[l] == ev, "R4 R5 out_valid", 128'(out_valid[l]), 128'(ev));
                if (ev) begin
                    chk(out_data[l*BW +: BW] == ctq[l][0], "R7 lane ciphertext", out_data[l*BW +: BW], ctq[l][0]);
                    void'(dueq[l].pop_front());
                    void'(ctq[l].pop_front());
                end
            end
        end
    end

    // ---------------- scenarios ----------------
    localparam logic [127:0] K1  = 128'h000102030405060708090a0b0c0d0e0f;
    localparam logic [127:0] P1  = 128'h00112233445566778899aabbccddeeff;
    localparam logic [127:0] C1  = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
    localparam logic [127:0] K2  = 128'h2b7e151628aed2a6abf7158809cf4f3c;
    localparam logic [127:0] P2  = 128'h3243f6a8885a308d313198a2e0370734;
    localparam logic [127:0] C2  = 128'h3925841d02dc09fbdc118597196a0b32;

    function automatic logic [127:0] mix_pt(input int j, input int l);
        return {32'(j), 32'(l), 32'hdeadbeef ^ 32'(j * 37 + l), 32'(j * 7 + l)};
    endfunction

    task automatic fill_all(input logic [127:0] v);
        for (int l = 0; l < NL; l++) in_data[l*BW +: BW] = v;
    endtask

    task automatic kat(input logic [127:0] pt, input logic [127:0] ct);
        fill_all(pt);
        in_valid = '1;
        @(negedge clk);
        in_valid = '0;
        repeat (10) @(negedge clk);
        for (int l = 0; l < NL; l++) begin
            chk(out_valid[l] == 1'b1, "R6 known-answer valid", 128'(out_valid[l]), 128'd1);
            chk(out_data[l*BW +: BW] == ct, "R6 known-answer value", out_data[l*BW +: BW], ct);
        end
    endtask

    initial begin
        int n;
        logic [127:0] o0;
        repeat (4) @(negedge clk);
        chk(key_ready == 1'b0, "R1 key_ready in reset", 128'(key_ready), 128'd0);
        chk(out_valid == '0, "R1 out_valid in reset", 128'(out_valid), 128'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(key_ready == 1'b0, "R1 key_ready after reset", 128'(key_ready), 128'd0);
        chk(out_valid == '0, "R1 out_valid after reset", 128'(out_valid), 128'd0);

        // R4: offers with no key loaded are dropped
        for (int j = 0; j < 3; j++) begin
            for (int l = 0; l < NL; l++) in_data[l*BW +: BW] = mix_pt(j + 100, l);
            in_valid = '1;
            @(negedge clk);
        end

        // R2: key load with empty pipelines, offers held high meanwhile (R4)
        key_in = K1;
        key_load = 1'b1;
        n = 0;
        do begin
            @(negedge clk);
            key_load = 1'b0;
            n++;
        end while (!key_ready && n < 60);
        in_valid = '0;
        chk(n == 12, "R2 ready delay empty", 128'(n), 128'd12);

        kat(P1, C1);

        // R7 R8: mixed-lane burst, lane 1 idle early, shared data every 4th cycle
        for (int j = 0; j < 40; j++) begin
            for (int l = 0; l < NL; l++) begin
                in_valid[l] = (l == 1 && j < 10) ? 1'b0 : (((j + l) % 3) != 0);
                in_data[l*BW +: BW] = (j % 4 == 0) ? mix_pt(j, 0) : mix_pt(j, l);
            end
            @(negedge clk);
        end
        in_valid = '0;
        repeat (12) @(negedge clk);

        // R8: same plaintext, different lanes and cycles
        fill_all(mix_pt(555, 9));
        in_valid = '1;
        @(negedge clk);
        in_valid = '0;
        repeat (2) @(negedge clk);
        in_valid = 3'b100;
        @(negedge clk);
        in_valid = '0;
        repeat (7) @(negedge clk);
        o0 = out_data[0 +: BW];
        chk(out_data[BW +: BW] == o0, "R8 lane1 equals lane0", out_data[BW +: BW], o0);
        chk(out_data[2*BW +: BW] == o0, "R8 lane2 equals lane0", out_data[2*BW +: BW], o0);
        repeat (3) @(negedge clk);
        chk(out_valid[2] == 1'b1, "R8 later copy valid", 128'(out_valid[2]), 128'd1);
        chk(out_data[2*BW +: BW] == o0, "R8 later copy equal", out_data[2*BW +: BW], o0);
        repeat (4) @(negedge clk);

        // R9: key change with blocks in flight
        for (int j = 0; j < 4; j++) begin
            for (int l = 0; l < NL; l++) in_data[l*BW +: BW] = mix_pt(j + 200, l);
            in_valid = '1;
            if (j < 3) @(negedge clk);
        end
        key_in = K2;
        key_load = 1'b1;
        n = 0;
        do begin
            @(negedge clk);
            key_load = 1'b0;
            for (int l = 0; l < NL; l++) in_data[l*BW +: BW] = mix_pt(n + 300, l);
            n++;
        end while (!key_ready && n < 80);
        in_valid = '0;
        chk(n == 23, "R9 ready delay after drain", 128'(n), 128'd23);

        kat(P2, C2);
        repeat (15) @(negedge clk);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog expired act=%0d exp=%0d", cyc, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule